// File: doc/BRIEF.md
# Ciphertext-Weight Key Hopping Stream Cipher

This block encrypts or decrypts one 256-bit packet per clock by XORing it with a 256-bit working key. The working key is a 64-bit running IV placed above one of four stored 192-bit secrets. Three of the secrets are user keys that take part in hopping. The fourth is reserved for authentication messages. The result and the working key that produced it appear one cycle later, with a valid flag.

After each ordinary packet the block counts the one bits of the ciphertext and compares that count with a shared threshold, then picks the key for the following packet. A count above the threshold moves forward one position in the ring of user keys. A count below it moves back one position. A count exactly equal keeps the current key. The IV steps by one for every ordinary packet, whatever the hop decision. A receiver running the same block in decrypt mode counts ones on its input, which is the ciphertext, so the key sequences at both ends stay aligned.

A session-start pulse returns the key choice to the first user key and loads the IV from a seed input. The user keys, the authentication key and the threshold can all be loaded from the side.

Top module: `key_hop_cipher`

## Requirements
- R1: After reset, out_valid_o, data_o and wkey_o are zero, the hop index selects user key 0, the IV is zero and the threshold is 128.
- R2: A packet accepted with in_valid_i high produces out_valid_o high one cycle later, with wkey_o = {IV, selected 192-bit key} (IV in bits 255:192) and data_o = data_i XOR wkey_o. out_valid_o is low one cycle after a cycle with in_valid_i low.
- R3: sess_start_i sets the hop index to user key 0 and the IV to iv_seed_i. A packet accepted in the same cycle is processed with that key and IV, and its hop and IV step then apply on top.
- R4: Every accepted non-authentication packet increments the IV by one, modulo 2^64, whichever way the key hops.
- R5: If the ciphertext one-count equals the threshold, the next packet uses the same user key.
- R6: If the one-count is above the threshold, the next packet uses the next user key. After user key 2 comes user key 0.
- R7: If the one-count is below the threshold, the next packet uses the previous user key. Before user key 0 comes user key 2.
- R8: With decrypt_i high, the one-count is taken on data_i (the ciphertext). With decrypt_i low, it is taken on the XOR result.
- R9: A packet with auth_i high uses the authentication key with the current IV and changes neither the hop index nor the IV.
- R10: thr_wr_i loads thr_data_i (9 bits) into the threshold only when in_valid_i and out_valid_o are both low. Otherwise the write is ignored.
- R11: key_wr_i loads key_data_i into the slot named by key_sel_i: codes 0, 1 and 2 are user keys 0, 1 and 2, and code 3 is the authentication key. A packet accepted in the same cycle as the write still uses the old key value.
- R12: In cycles with in_valid_i low and no session start, the hop index and the IV hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sess_start_i | input | 1 | Session restart pulse |
| iv_seed_i | input | 64 | IV value loaded at session start |
| key_wr_i | input | 1 | Key slot write strobe |
| key_sel_i | input | 2 | Key slot: 0..2 user keys, 3 authentication key |
| key_data_i | input | 192 | Key value to write |
| thr_wr_i | input | 1 | Threshold write strobe (accepted only when idle) |
| thr_data_i | input | 9 | New threshold value |
| in_valid_i | input | 1 | Packet valid |
| decrypt_i | input | 1 | 1 = decrypt, 0 = encrypt |
| auth_i | input | 1 | Packet is an authentication message |
| data_i | input | 256 | Input packet |
| out_valid_o | output | 1 | Result valid |
| data_o | output | 256 | XOR result |
| wkey_o | output | 256 | Working key used for the result |

## Verification
A wrong hop index or IV stays hidden inside the block, but it appears in wkey_o on the very next accepted packet. The upper 64 bits of wkey_o expose an IV that failed to step or stepped twice. The lower 192 bits expose a hop in the wrong direction, a missing wrap, or an update caused by an authentication packet. The bench constructs each packet so that its ciphertext has a chosen one-count, landing on, just above or just below the threshold, and at 0 and 256. In that way every hop decision and every threshold change is confirmed one packet later. A threshold write that was wrongly accepted or wrongly dropped only shows up in the hop that follows, so those cases are always followed by a packet whose count falls between the old and the new threshold.

// File: rtl/key_hop_pkg.sv
package key_hop_pkg;
  localparam int unsigned DEF_DATA_W = 256;
  localparam int unsigned DEF_IV_W   = 64;
  localparam int unsigned DEF_N_USER = 3;
  localparam int unsigned DEF_THR    = 128;

  typedef enum logic [1:0] {
    HOP_KEEP = 2'd0,
    HOP_NEXT = 2'd1,
    HOP_PREV = 2'd2
  } hop_e;
endpackage

// File: rtl/khc_key_bank.sv
module khc_key_bank #(
  parameter int unsigned KEY_W  = 192,
  parameter int unsigned N_USER = 3,
  localparam int unsigned SEL_W = $clog2(N_USER + 1),
  localparam int unsigned IDX_W = $clog2(N_USER)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             rd_auth_i,
  output logic [KEY_W-1:0] rd_key_o
);
  logic [KEY_W-1:0] user_q [N_USER];
  logic [KEY_W-1:0] auth_q;

  for (genvar k = 0; k < N_USER; k++) begin : g_user
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  user_q[k] <= '0;
      else if (wr_i && wr_sel_i == SEL_W'(k))       user_q[k] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  auth_q <= '0;
    else if (wr_i && wr_sel_i == SEL_W'(N_USER))  auth_q <= wr_data_i;
  end

  always_comb begin
    rd_key_o = '0;
    if (rd_auth_i) rd_key_o = auth_q;
    else begin
      for (int k = 0; k < N_USER; k++)
        if (rd_idx_i == IDX_W'(k)) rd_key_o = user_q[k];
    end
  end
endmodule

// File: rtl/khc_popcount.sv
module khc_popcount #(
  parameter int unsigned DATA_W = 256,
  parameter int unsigned GRP    = 16,
  localparam int unsigned N_GRP = (DATA_W + GRP - 1) / GRP,
  localparam int unsigned PW    = $clog2(GRP + 1),
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] vec_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PW-1:0] part [N_GRP];

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_comb begin
      part[g] = '0;
      for (int b = 0; b < GRP; b++)
        if (g * GRP + b < DATA_W)
          part[g] = part[g] + PW'(vec_i[g*GRP+b]);
    end
  end

  always_comb begin
    cnt_o = '0;
    for (int g = 0; g < N_GRP; g++)
      cnt_o = cnt_o + CNT_W'(part[g]);
  end
endmodule

// File: rtl/khc_hop_ctrl.sv
module khc_hop_ctrl
  import key_hop_pkg::*;
#(
  parameter int unsigned DATA_W  = 256,
  parameter int unsigned IV_W    = 64,
  parameter int unsigned N_USER  = 3,
  parameter int unsigned THR_RST = 128,
  localparam int unsigned IDX_W  = $clog2(N_USER),
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sess_start_i,
  input  logic [IV_W-1:0]  iv_seed_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] weight_i,
  input  logic             thr_wr_i,
  input  logic [CNT_W-1:0] thr_data_i,
  output logic [IDX_W-1:0] cur_idx_o,
  output logic [IV_W-1:0]  cur_iv_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_USER - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IV_W-1:0]  iv_q;
  logic [CNT_W-1:0] thr_q;
  hop_e             hop;

  assign cur_idx_o = sess_start_i ? '0 : idx_q;
  assign cur_iv_o  = sess_start_i ? iv_seed_i : iv_q;

  always_comb begin
    if (weight_i > thr_q)      hop = HOP_NEXT;
    else if (weight_i < thr_q) hop = HOP_PREV;
    else                       hop = HOP_KEEP;
  end

  always_comb begin
    unique case (hop)
      HOP_NEXT: idx_d = (cur_idx_o == LAST) ? '0 : cur_idx_o + 1'b1;
      HOP_PREV: idx_d = (cur_idx_o == '0) ? LAST : cur_idx_o - 1'b1;
      default:  idx_d = cur_idx_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      iv_q  <= '0;
    end else if (accept_i) begin
      idx_q <= idx_d;
      iv_q  <= cur_iv_o + 1'b1;
    end else if (sess_start_i) begin
      idx_q <= '0;
      iv_q  <= iv_seed_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       thr_q <= CNT_W'(THR_RST);
    else if (thr_wr_i) thr_q <= thr_data_i;
  end
endmodule

// File: rtl/key_hop_cipher.sv
module key_hop_cipher
  import key_hop_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned IV_W    = DEF_IV_W,
  parameter int unsigned N_USER  = DEF_N_USER,
  parameter int unsigned THR_RST = DEF_THR,
  localparam int unsigned KEY_W  = DATA_W - IV_W,
  localparam int unsigned SEL_W  = $clog2(N_USER + 1),
  localparam int unsigned IDX_W  = $clog2(N_USER),
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sess_start_i,
  input  logic [IV_W-1:0]   iv_seed_i,
  input  logic              key_wr_i,
  input  logic [SEL_W-1:0]  key_sel_i,
  input  logic [KEY_W-1:0]  key_data_i,
  input  logic              thr_wr_i,
  input  logic [CNT_W-1:0]  thr_data_i,
  input  logic              in_valid_i,
  input  logic              decrypt_i,
  input  logic              auth_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] wkey_o
);
  logic [IDX_W-1:0]  cur_idx;
  logic [IV_W-1:0]   cur_iv;
  logic [KEY_W-1:0]  sel_key;
  logic [DATA_W-1:0] wkey, xored, cipher;
  logic [CNT_W-1:0]  weight;
  logic              accept, thr_wr_ok;

  assign accept    = in_valid_i && !auth_i;
  assign thr_wr_ok = thr_wr_i && !in_valid_i && !out_valid_o;

  khc_key_bank #(.KEY_W(KEY_W), .N_USER(N_USER)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (key_wr_i),
    .wr_sel_i  (key_sel_i),
    .wr_data_i (key_data_i),
    .rd_idx_i  (cur_idx),
    .rd_auth_i (auth_i),
    .rd_key_o  (sel_key)
  );

  assign wkey   = {cur_iv, sel_key};
  assign xored  = data_i ^ wkey;
  assign cipher = decrypt_i ? data_i : xored;

  khc_popcount #(.DATA_W(DATA_W)) u_pop (
    .vec_i (cipher),
    .cnt_o (weight)
  );

  khc_hop_ctrl #(
    .DATA_W(DATA_W), .IV_W(IV_W), .N_USER(N_USER), .THR_RST(THR_RST)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sess_start_i (sess_start_i),
    .iv_seed_i    (iv_seed_i),
    .accept_i     (accept),
    .weight_i     (weight),
    .thr_wr_i     (thr_wr_ok),
    .thr_data_i   (thr_data_i),
    .cur_idx_o    (cur_idx),
    .cur_iv_o     (cur_iv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      data_o      <= '0;
      wkey_o      <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        data_o <= xored;
        wkey_o <= wkey;
      end
    end
  end
endmodule

// File: rtl/key_hop_cipher_chk.sv
module key_hop_cipher_chk #(
  parameter int unsigned DATA_W = 256,
  parameter int unsigned IV_W   = 64,
  parameter int unsigned N_USER = 3,
  localparam int unsigned IDX_W = $clog2(N_USER)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sess_start_i,
  input logic [IV_W-1:0]   iv_seed_i,
  input logic              in_valid_i,
  input logic              auth_i,
  input logic [DATA_W-1:0] data_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [DATA_W-1:0] wkey_o,
  input logic [IDX_W-1:0]  idx_q,
  input logic [IV_W-1:0]   iv_q
);
  a_r2_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> out_valid_o == $past(in_valid_i));

  a_r2_xor_relation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (data_o ^ wkey_o) == $past(data_i));

  a_r6_idx_in_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(N_USER));

  a_r4_iv_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !auth_i && !sess_start_i) |=> iv_q == $past(iv_q) + 1'b1);

  a_r9_auth_no_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && auth_i && !sess_start_i) |=> $stable(iv_q) && $stable(idx_q));

  a_r3_session_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sess_start_i && !(in_valid_i && !auth_i)) |=> idx_q == '0 && iv_q == $past(iv_seed_i));

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !sess_start_i) |=> $stable(iv_q) && $stable(idx_q));
endmodule

bind key_hop_cipher key_hop_cipher_chk #(
  .DATA_W(DATA_W), .IV_W(IV_W), .N_USER(N_USER)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sess_start_i (sess_start_i),
  .iv_seed_i    (iv_seed_i),
  .in_valid_i   (in_valid_i),
  .auth_i       (auth_i),
  .data_i       (data_i),
  .out_valid_o  (out_valid_o),
  .data_o       (data_o),
  .wkey_o       (wkey_o),
  .idx_q        (u_ctrl.idx_q),
  .iv_q         (u_ctrl.iv_q)
);

// File: tb/key_hop_cipher_tb_top.sv
module key_hop_cipher_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 256;
  localparam int IW = 64;
  localparam int KW = 192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sess_start = 1'b0;
  logic [IW-1:0] iv_seed = '0;
  logic          key_wr = 1'b0;
  logic [1:0]    key_sel = '0;
  logic [KW-1:0] key_data = '0;
  logic          thr_wr = 1'b0;
  logic [8:0]    thr_data = '0;
  logic          in_valid = 1'b0;
  logic          decrypt = 1'b0;
  logic          auth = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          out_valid;
  logic [DW-1:0] data_out, wkey_out;

  key_hop_cipher dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sess_start_i(sess_start), .iv_seed_i(iv_seed),
    .key_wr_i(key_wr), .key_sel_i(key_sel), .key_data_i(key_data),
    .thr_wr_i(thr_wr), .thr_data_i(thr_data), .in_valid_i(in_valid),
    .decrypt_i(decrypt), .auth_i(auth), .data_i(data_in),
    .out_valid_o(out_valid), .data_o(data_out), .wkey_o(wkey_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [KW-1:0] m_key [4];
  int            m_idx;
  logic [IW-1:0] m_iv;
  int            m_thr;

  typedef struct packed { logic dec; logic au; logic [8:0] w; } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 9'd128},  // R5 keep key 0
    '{1'b0, 1'b0, 9'd200},  // R6 0->1
    '{1'b0, 1'b0, 9'd129},  // R6 1->2
    '{1'b0, 1'b0, 9'd255},  // R6 wrap 2->0
    '{1'b0, 1'b0, 9'd10},   // R7 wrap 0->2
    '{1'b1, 1'b0, 9'd127},  // R8 R7 2->1
    '{1'b1, 1'b0, 9'd128},  // R8 R5 keep 1
    '{1'b0, 1'b1, 9'd0},    // R9 auth, no change
    '{1'b0, 1'b0, 9'd256},  // R6 1->2
    '{1'b1, 1'b0, 9'd0},    // R7 2->1
    '{1'b1, 1'b1, 9'd256},  // R9 auth decrypt
    '{1'b0, 1'b0, 9'd128}   // R5 keep 1
  };

  function automatic logic [DW-1:0] ones(int w);
    logic [DW-1:0] v = '0;
    for (int b = 0; b < DW; b++) if (b < w) v[b] = 1'b1;
    return {v[DW-1:DW-7], v[DW-8:0]} ^ ({DW{1'b0}});
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_key(int slot, logic [KW-1:0] v);
    @(negedge clk);
    key_wr = 1'b1; key_sel = 2'(slot); key_data = v;
    @(negedge clk);
    key_wr = 1'b0;
    m_key[slot] = v;
  endtask

  // one packet whose ciphertext has w ones; checks R2 plus the key choice
  task automatic pkt(bit dec, bit au, int w, string req, bit sess = 1'b0,
                     logic [IW-1:0] seed = '0, bit kw = 1'b0);
    logic [DW-1:0] key, cip, din, dexp;
    if (sess) begin m_idx = 0; m_iv = seed; end
    key  = {m_iv, m_key[au ? 3 : m_idx]};
    cip  = ones(w);
    din  = dec ? cip : (cip ^ key);
    dexp = din ^ key;
    @(negedge clk);
    in_valid = 1'b1; decrypt = dec; auth = au; data_in = din;
    sess_start = sess; iv_seed = seed;
    if (kw) begin key_wr = 1'b1; key_sel = 2'(m_idx); key_data = ~m_key[m_idx]; end
    @(negedge clk);
    in_valid = 1'b0; sess_start = 1'b0; key_wr = 1'b0;
    if (kw) m_key[m_idx] = ~m_key[m_idx];
    chk(out_valid == 1'b1, {req, " valid"}, DW'(out_valid), DW'(1));
    chk(wkey_out == key, {req, " wkey"}, wkey_out, key);
    chk(data_out == dexp, {req, " data"}, data_out, dexp);
    if (!au) begin
      m_iv = m_iv + 1'b1;
      if (w > m_thr) m_idx = (m_idx + 1) % 3;
      else if (w < m_thr) m_idx = (m_idx + 2) % 3;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_idx = 0; m_iv = '0; m_thr = 128;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 valid", DW'(out_valid), '0);
    chk(data_out == '0, "R1 data", data_out, '0);
    chk(wkey_out == '0, "R1 wkey", wkey_out, '0);
    rst_n = 1'b1;
    // R11 key loads
    load_key(0, {3{64'h0123456789abcdef}});
    load_key(1, {3{64'hf0e1d2c3b4a59687}});
    load_key(2, {6{32'hdeadbeef}});
    load_key(3, {12{16'h5a3c}});
    // R1 first packet uses key 0, IV 0 and default threshold 128
    for (int i = 0; i < NV; i++)
      pkt(VECS[i].dec, VECS[i].au, int'(VECS[i].w), $sformatf("R2 vec%0d", i));
    // R2 valid drops after an idle cycle
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 valid low", DW'(out_valid), '0);
    // R12 idle gap keeps IV and index
    repeat (5) @(negedge clk);
    pkt(1'b0, 1'b0, 128, "R12 idle hold");
    // R10 write threshold while idle
    @(negedge clk);
    @(negedge clk);
    thr_wr = 1'b1; thr_data = 9'd40;
    @(negedge clk);
    thr_wr = 1'b0; m_thr = 40;
    pkt(1'b0, 1'b0, 40, "R10 R5 new thr keep");
    pkt(1'b0, 1'b0, 41, "R10 R6 new thr next");
    // R10 write while busy ignored
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1; thr_wr = 1'b1; thr_data = 9'd200;
    data_in = ones(100) ^ {m_iv, m_key[m_idx]}; decrypt = 1'b0; auth = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; thr_wr = 1'b0;
    m_iv = m_iv + 1'b1; m_idx = (m_idx + 1) % 3;
    pkt(1'b0, 1'b0, 150, "R10 busy write ignored");
    pkt(1'b0, 1'b0, 39, "R10 R7 below thr");
    // R3 session start alone, seed all ones
    @(negedge clk);
    sess_start = 1'b1; iv_seed = '1;
    @(negedge clk);
    sess_start = 1'b0; m_idx = 0; m_iv = '1;
    pkt(1'b0, 1'b0, 100, "R3 session reload");
    pkt(1'b1, 1'b0, 40, "R4 iv wrap to zero");
    // R3 session start with same-cycle packet
    pkt(1'b0, 1'b0, 41, "R3 same-cycle start", 1'b1, 64'h0000_0000_0000_0100);
    pkt(1'b0, 1'b0, 40, "R3 after same-cycle start");
    // R11 key write during packet: old key used, new key next
    pkt(1'b0, 1'b0, 40, "R11 write same cycle old key", 1'b0, '0, 1'b1);
    pkt(1'b0, 1'b0, 40, "R11 new key visible");
    pkt(1'b0, 1'b1, 7, "R9 auth after hops");
    pkt(1'b1, 1'b0, 40, "R9 state unchanged by auth");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule